// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This block turns the result of a quiet floating-point comparison between stack register 0 and stack register j into the integer status flags. It also makes the stack decisions that go with that compare. An external comparator supplies a relation code. The block also receives:

- the empty tags of both operand registers,
- the masking state of the invalid-operation exception,
- a summary of any other unmasked exception raised by the compare,
- the pop request decoded from the instruction.

One cycle after a start strobe, the block presents:

- the six arithmetic flags,
- a stack-underflow exception strobe,
- a strobe that clears condition code C1,
- a single pop strobe when the stack must pop.

An illegal relation code leaves the flags untouched and raises an error strobe.

The comparison itself, delivery of exceptions and the register stack storage sit outside the block. The surrounding pipeline pulses `start` once per compare instruction. It acts on the one-cycle strobes while `done` is high.

Top module: `fcmp_flag_unit`

## Requirements
- R1: With both operands present, relation code 3 (unordered) sets ZF, PF and CF and clears the rest. Flag vector bits are CF=0, PF=1, AF=2, ZF=3, SF=4, OF=5, so the value is 0x0B.
- R2: With both operands present, relation code 2 (greater) clears all six flags (value 0x00).
- R3: With both operands present, relation code 0 (less) sets only CF (value 0x01).
- R4: With both operands present, relation code 1 (equal) sets only ZF (value 0x08).
- R5: OF, SF and AF (bits 5, 4 and 2) are zero whenever the flags are written.
- R6: If either operand tag is empty, the block pulses `underflow` and writes flags 0x0B, whatever the relation code is, including illegal codes.
- R7: On the underflow path, `pop` pulses only when `inv_masked` is 1 and `pop_req` is 1.
- R8: On the normal path with a legal code, `pop` pulses only when `pop_req` is 1 and `exc_pending` is 0.
- R9: Every executed compare pulses `c1_clear`, on every path.
- R10: With both operands present, a relation code of 4 to 7 pulses `rel_error`, keeps the previous flag value and gives no pop.
- R11: All outputs are registered. The strobes `done`, `c1_clear`, `underflow`, `pop` and `rel_error` are high only in the cycle after a cycle with `start` high, so each instruction gives at most one pop pulse.
- R12: During reset, all strobes are 0 and the flag vector is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One instruction execution per high cycle |
| tag_empty_st0 | input | 1 | Stack register 0 is tagged empty |
| tag_empty_stj | input | 1 | Stack register j is tagged empty |
| rel_code | input | 3 | Comparator relation: 0 less, 1 equal, 2 greater, 3 unordered, 4-7 illegal |
| inv_masked | input | 1 | Invalid-operation exception is masked |
| exc_pending | input | 1 | The compare raised an unmasked exception |
| pop_req | input | 1 | Instruction requests a stack pop (opcode bit 2) |
| flags | output | 6 | {OF,SF,ZF,AF,PF,CF} |
| done | output | 1 | Results valid this cycle |
| c1_clear | output | 1 | Clear condition code C1 |
| underflow | output | 1 | Stack-underflow exception strobe |
| pop | output | 1 | Pop the register stack |
| rel_error | output | 1 | Illegal relation code seen |

## Verification
Several properties are checked on every cycle:

- the three always-zero flags stay clear,
- an underflow strobe always carries flags 0x0B,
- an error strobe never moves the flags,
- no strobe appears outside the cycle after a start,
- underflow and error never come together.

Only the bench's scenarios can show that each relation code gives the correct flag value. The same holds for the pop decision, which depends on the mask, the pending exception and the pop request on both paths. The bench also shows that an empty tag really overrides an illegal relation code.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
    localparam int FLAG_W = 6;
    localparam int REL_W  = 3;

    localparam int CF_IDX = 0;
    localparam int PF_IDX = 1;
    localparam int AF_IDX = 2;
    localparam int ZF_IDX = 3;
    localparam int SF_IDX = 4;
    localparam int OF_IDX = 5;

    localparam logic [REL_W-1:0] REL_LESS    = 3'd0;
    localparam logic [REL_W-1:0] REL_EQUAL   = 3'd1;
    localparam logic [REL_W-1:0] REL_GREATER = 3'd2;
    localparam logic [REL_W-1:0] REL_UNORD   = 3'd3;

    localparam logic [FLAG_W-1:0] FLAGS_UNORD =
        FLAG_W'((1 << ZF_IDX) | (1 << PF_IDX) | (1 << CF_IDX));
    localparam logic [FLAG_W-1:0] FLAGS_LESS  = FLAG_W'(1 << CF_IDX);
    localparam logic [FLAG_W-1:0] FLAGS_EQUAL = FLAG_W'(1 << ZF_IDX);
    localparam logic [FLAG_W-1:0] FLAGS_ZERO_MASK =
        FLAG_W'((1 << OF_IDX) | (1 << SF_IDX) | (1 << AF_IDX));

    typedef struct packed {
        logic              done;
        logic              c1_clr;
        logic              unf;
        logic              pop;
        logic              err;
        logic [FLAG_W-1:0] flags;
    } cmp_state_t;
endpackage

// File: rtl/fcmp_rel_map.sv
module fcmp_rel_map
    import fcmp_pkg::*;
(
    input  logic [REL_W-1:0]  rel,
    output logic [FLAG_W-1:0] rel_flags,
    output logic              rel_legal
);
    always_comb begin
        rel_legal = 1'b1;
        rel_flags = '0;
        case (rel)
            REL_LESS:    rel_flags = FLAGS_LESS;
            REL_EQUAL:   rel_flags = FLAGS_EQUAL;
            REL_GREATER: rel_flags = '0;
            REL_UNORD:   rel_flags = FLAGS_UNORD;
            default:     rel_legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/fcmp_pop_ctrl.sv
module fcmp_pop_ctrl (
    input  logic empty_any,
    input  logic inv_masked,
    input  logic exc_pending,
    input  logic pop_req,
    input  logic rel_legal,
    output logic pop_ok
);
    always_comb begin
        if (empty_any)
            pop_ok = pop_req & inv_masked;
        else if (!rel_legal)
            pop_ok = 1'b0;
        else
            pop_ok = pop_req & ~exc_pending;
    end
endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
    import fcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tag_empty_st0,
    input  logic              tag_empty_stj,
    input  logic [REL_W-1:0]  rel_code,
    input  logic              inv_masked,
    input  logic              exc_pending,
    input  logic              pop_req,
    output logic [FLAG_W-1:0] flags,
    output logic              done,
    output logic              c1_clear,
    output logic              underflow,
    output logic              pop,
    output logic              rel_error
);
    cmp_state_t        s_d, s_q;
    logic [FLAG_W-1:0] rel_flags;
    logic              rel_legal;
    logic              empty_any;
    logic              pop_ok;

    assign empty_any = tag_empty_st0 | tag_empty_stj;

    fcmp_rel_map u_map (
        .rel       (rel_code),
        .rel_flags (rel_flags),
        .rel_legal (rel_legal)
    );

    fcmp_pop_ctrl u_pop (
        .empty_any   (empty_any),
        .inv_masked  (inv_masked),
        .exc_pending (exc_pending),
        .pop_req     (pop_req),
        .rel_legal   (rel_legal),
        .pop_ok      (pop_ok)
    );

    always_comb begin
        s_d        = s_q;
        s_d.done   = 1'b0;
        s_d.c1_clr = 1'b0;
        s_d.unf    = 1'b0;
        s_d.pop    = 1'b0;
        s_d.err    = 1'b0;
        if (start) begin
            s_d.done   = 1'b1;
            s_d.c1_clr = 1'b1;
            s_d.pop    = pop_ok;
            if (empty_any) begin
                s_d.unf   = 1'b1;
                s_d.flags = FLAGS_UNORD;
            end else if (!rel_legal) begin
                s_d.err   = 1'b1;
            end else begin
                s_d.flags = rel_flags;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign flags     = s_q.flags;
    assign done      = s_q.done;
    assign c1_clear  = s_q.c1_clr;
    assign underflow = s_q.unf;
    assign pop       = s_q.pop;
    assign rel_error = s_q.err;

    assert_zero_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flags & FLAGS_ZERO_MASK) == '0);

    assert_unf_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> flags == FLAGS_UNORD);

    assert_err_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rel_error |-> $stable(flags));

    assert_err_no_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rel_error |-> !pop && !underflow);

    assert_start_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done && c1_clear);

    assert_no_idle_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done && !c1_clear && !pop && !underflow && !rel_error);

    assert_c1_each_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> c1_clear);
endmodule

// File: tb/fcmp_flag_unit_test.sv
module fcmp_flag_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       t0 = 1'b0, tj = 1'b0;
    logic [2:0] rel = 3'd0;
    logic       imask = 1'b0, pexc = 1'b0, preq = 1'b0;
    logic [5:0] flags;
    logic       done, c1_clear, underflow, pop, rel_error;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    fcmp_flag_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .tag_empty_st0(t0), .tag_empty_stj(tj), .rel_code(rel),
        .inv_masked(imask), .exc_pending(pexc), .pop_req(preq),
        .flags(flags), .done(done), .c1_clear(c1_clear),
        .underflow(underflow), .pop(pop), .rel_error(rel_error)
    );

    // {t0,tj,rel[2:0],imask,pexc,preq, exp_flags[5:0],exp_unf,exp_pop,exp_err}
    localparam int NV = 12;
    localparam logic [16:0] VEC [NV] = '{
        {1'b0,1'b0,3'd3,1'b0,1'b0,1'b0, 6'h0B,1'b0,1'b0,1'b0}, // R1
        {1'b0,1'b0,3'd2,1'b0,1'b0,1'b1, 6'h00,1'b0,1'b1,1'b0}, // R2 R8
        {1'b0,1'b0,3'd0,1'b0,1'b1,1'b1, 6'h01,1'b0,1'b0,1'b0}, // R3 R8
        {1'b0,1'b0,3'd5,1'b1,1'b0,1'b1, 6'h01,1'b0,1'b0,1'b1}, // R10
        {1'b0,1'b0,3'd1,1'b0,1'b0,1'b1, 6'h08,1'b0,1'b1,1'b0}, // R4 R8
        {1'b0,1'b0,3'd1,1'b1,1'b0,1'b0, 6'h08,1'b0,1'b0,1'b0}, // R4 R8
        {1'b1,1'b0,3'd0,1'b1,1'b0,1'b1, 6'h0B,1'b1,1'b1,1'b0}, // R6 R7
        {1'b0,1'b1,3'd2,1'b0,1'b0,1'b1, 6'h0B,1'b1,1'b0,1'b0}, // R6 R7
        {1'b1,1'b1,3'd2,1'b1,1'b0,1'b0, 6'h0B,1'b1,1'b0,1'b0}, // R7
        {1'b1,1'b0,3'd7,1'b1,1'b1,1'b1, 6'h0B,1'b1,1'b1,1'b0}, // R6 illegal ignored
        {1'b0,1'b0,3'd2,1'b1,1'b0,1'b0, 6'h00,1'b0,1'b0,1'b0}, // R2
        {1'b0,1'b0,3'd6,1'b0,1'b0,1'b1, 6'h00,1'b0,1'b0,1'b1}  // R10
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic run_vec(input logic [16:0] v, input int idx);
        @(negedge clk);
        {t0, tj, rel, imask, pexc, preq} = v[16:9];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        $display("vector %0d", idx);
        chk("R1-R4/R6 flags", {2'b0, flags}, {2'b0, v[8:3]});
        chk("R5 zero flags", {2'b0, flags & 6'h34}, 8'h00);
        chk("R6 underflow", {7'b0, underflow}, {7'b0, v[2]});
        chk("R7/R8 pop", {7'b0, pop}, {7'b0, v[1]});
        chk("R10 rel_error", {7'b0, rel_error}, {7'b0, v[0]});
        chk("R9 c1_clear", {7'b0, c1_clear}, 8'h01);
        chk("R11 done", {7'b0, done}, 8'h01);
        @(negedge clk);
        chk("R11 idle strobes", {3'b0, done, c1_clear, underflow, pop, rel_error}, 8'h00);
        chk("R11 flags hold", {2'b0, flags}, {2'b0, v[8:3]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R12 reset flags", {2'b0, flags}, 8'h00);
        chk("R12 reset strobes", {3'b0, done, c1_clear, underflow, pop, rel_error}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 no start no done", {7'b0, done}, 8'h00);

        for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

        // back-to-back starts: two executions, one pop pulse each
        @(negedge clk);
        {t0, tj, rel, imask, pexc, preq} = {1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1};
        start = 1'b1;
        @(negedge clk);
        chk("R3 b2b first flags", {2'b0, flags}, 8'h01);
        chk("R11 b2b first pop", {7'b0, pop}, 8'h01);
        rel = 3'd1;
        preq = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk("R4 b2b second flags", {2'b0, flags}, 8'h08);
        chk("R11 b2b second no pop", {7'b0, pop}, 8'h00);
        chk("R9 b2b c1_clear", {7'b0, c1_clear}, 8'h01);

        // reset mid-run clears state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R12 reset again flags", {2'b0, flags}, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule